// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block drives four independent pulse-width-modulated outputs. Each channel is set up through a single-cycle register port. Software writes a terminal count that sets the period, a duty value that sets how long the output is active, and a control word. The control word picks a prescale code and the output polarity. Setting the channel's enable bit starts its waveform. Clearing the bit parks the output at its idle level and clears its counter.

The prescale code has two kinds of setting. The top code inserts a true clock divider, so the period counter moves once every 4096 clocks. The middle codes do not divide the clock. They shift the stored count left inside the fixed-width counter, and any bits shifted past the top are lost. Shadow copies of the duty and period are reloaded only at a period boundary, so a reconfiguration never produces a truncated cycle.

Top module: `pwm_quad`

## Requirements
- R1: Channel c's registers sit at byte address c*16 plus 0 (enable, bit 0), 4 (control: bits [2:0] prescale code, bit 3 invert), 8 (duty, 16 bits) and 12 (terminal count, 16 bits). Address bits [1:0] are ignored. Reads are combinational and return the last value written, with every unimplemented bit read as zero.
- R2: After reset every register reads zero and every output is low.
- R3: A channel with enable bit 0 set runs. Its first clock after the enabling write is count 0. Clearing the bit puts the output at the idle level from the next cycle and clears the counter, so a later enable restarts the waveform at count 0.
- R4: With normal polarity, code 0 and period P ≥ 2, the counter runs 0..P-1 and the output is high while the count is below the duty value. P of 0 or 1 holds the count at 0.
- R5: A duty of 0 gives a constant inactive output. A duty at or above the period gives a constant active output.
- R6: Control bit 3 inverts the output. This applies to the idle level of a disabled channel too, which is high when inverted and low otherwise.
- R7: Codes 1 to 6 shift both duty and terminal count left by 2, 3, 4, 6, 8 and 10 bits respectively, truncated to 16 bits, and leave the clock undivided. Codes 0 and 7 apply no shift.
- R8: Code 7 advances the period counter once every 4096 clocks.
- R9: Duty and period written while a channel runs take effect at the next period boundary. The current period completes with the old values.
- R10: Channels run independently. Writes and activity on one channel do not change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The waveform is tried with several duty/period pairs and compared cycle by cycle. A mid-range duty shows where the active-to-inactive edge falls. Duty of zero and duty at or above the period separate the two clamped cases from a comparator off by one count. Inverted channels separate the polarity handling of running and idle states. Shifted codes use terminal counts with high bits set, so a shift without truncation gives a different period. The divide-by-4096 code is run for full periods, and a mid-period rewrite shows whether reload waits for the boundary. Two channels staggered by a cycle expose any coupling between them.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PSW = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(NCH)+3:0]         reg_addr,
  input  logic [31:0]                    reg_wdata,
  input  logic                           reg_we,
  output logic [31:0]                    reg_rdata,
  output logic [NCH-1:0]                 pwm_out
);
  localparam int AW  = $clog2(NCH) + 4;
  localparam int CHW = $clog2(NCH);

  logic          en_q    [NCH];
  logic [3:0]    ctl_q   [NCH];
  logic [CW-1:0] duty_q  [NCH];
  logic [CW-1:0] tc_q    [NCH];
  logic [CW-1:0] cnt_q   [NCH];
  logic [CW-1:0] sduty_q [NCH];
  logic [CW-1:0] sper_q  [NCH];
  logic [PSW-1:0] pre_q  [NCH];
  logic          tick    [NCH];
  logic          roll    [NCH];

  function automatic logic [3:0] shamt(input logic [2:0] code);
    case (code)
      3'd1: shamt = 4'd2;
      3'd2: shamt = 4'd3;
      3'd3: shamt = 4'd4;
      3'd4: shamt = 4'd6;
      3'd5: shamt = 4'd8;
      3'd6: shamt = 4'd10;
      default: shamt = 4'd0;
    endcase
  endfunction

  wire [CHW-1:0] sel_ch = reg_addr[AW-1:4];
  wire [1:0]     field  = reg_addr[3:2];

  always_comb begin
    case (field)
      2'd0:    reg_rdata = 32'(en_q[sel_ch]);
      2'd1:    reg_rdata = 32'(ctl_q[sel_ch]);
      2'd2:    reg_rdata = 32'(duty_q[sel_ch]);
      default: reg_rdata = 32'(tc_q[sel_ch]);
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire           hit   = reg_we && (sel_ch == CHW'(i));
    wire [2:0]     code  = ctl_q[i][2:0];
    wire [CW-1:0]  eff_d = duty_q[i] << shamt(code);
    wire [CW-1:0]  eff_p = tc_q[i] << shamt(code);
    wire           last  = ({1'b0, cnt_q[i]} + 1'b1) >= {1'b0, sper_q[i]};

    assign tick[i] = (code != 3'd7) || (pre_q[i] == '1);
    assign roll[i] = en_q[i] && tick[i] && last;
    assign pwm_out[i] = en_q[i] ? ((cnt_q[i] < sduty_q[i]) ^ ctl_q[i][3]) : ctl_q[i][3];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        ctl_q[i]  <= '0;
        duty_q[i] <= '0;
        tc_q[i]   <= '0;
      end else if (hit) begin
        case (field)
          2'd0:    en_q[i]   <= reg_wdata[0];
          2'd1:    ctl_q[i]  <= reg_wdata[3:0];
          2'd2:    duty_q[i] <= reg_wdata[CW-1:0];
          default: tc_q[i]   <= reg_wdata[CW-1:0];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i]   <= '0;
        pre_q[i]   <= '0;
        sduty_q[i] <= '0;
        sper_q[i]  <= '0;
      end else if (!en_q[i]) begin
        cnt_q[i]   <= '0;
        pre_q[i]   <= '0;
        sduty_q[i] <= eff_d;
        sper_q[i]  <= eff_p;
      end else begin
        pre_q[i] <= (code == 3'd7) ? pre_q[i] + 1'b1 : '0;
        if (tick[i]) begin
          if (last) begin
            cnt_q[i]   <= '0;
            sduty_q[i] <= eff_d;
            sper_q[i]  <= eff_p;
          end else begin
            cnt_q[i] <= cnt_q[i] + 1'b1;
          end
        end
      end
    end
  end
endmodule

module pwm_quad_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PSW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pwm_out,
  input logic           en_q    [NCH],
  input logic [3:0]     ctl_q   [NCH],
  input logic [CW-1:0]  cnt_q   [NCH],
  input logic [CW-1:0]  sduty_q [NCH],
  input logic [CW-1:0]  sper_q  [NCH],
  input logic [PSW-1:0] pre_q   [NCH],
  input logic           tick    [NCH],
  input logic           roll    [NCH]
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_idle_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> cnt_q[i] == '0);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && tick[i] && !roll[i]) |=> cnt_q[i] == $past(cnt_q[i]) + 1'b1);
    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && sduty_q[i] == '0) |-> pwm_out[i] == ctl_q[i][3]);
    assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && sper_q[i] != '0 && sduty_q[i] >= sper_q[i]) |-> pwm_out[i] != ctl_q[i][3]);
    assert_slow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && ctl_q[i][2:0] == 3'd7 && pre_q[i] != '1) |=> $stable(cnt_q[i]));
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !roll[i]) |=> ($stable(sduty_q[i]) && $stable(sper_q[i])));
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .en_q(en_q), .ctl_q(ctl_q),
  .cnt_q(cnt_q), .sduty_q(sduty_q), .sper_q(sper_q), .pre_q(pre_q),
  .tick(tick), .roll(roll)
);

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  pwm_quad i_pwm_quad (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                       .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  typedef struct { logic [3:0] v; string tag; } item_t;
  item_t q[$];
  int checks = 0, errs = 0;
  logic [3:0] bg = 4'b0000;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      chk(pwm_out === it.v, it.tag, 32'(pwm_out), 32'(it.v));
    end
  end

  function automatic int sh(int code);
    case (code)
      1: return 2; 2: return 3; 3: return 4; 4: return 6; 5: return 8; 6: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic int eff(int v, int code);
    return (v << sh(code)) & 32'hFFFF;
  endfunction

  function automatic bit mdl(int d, int p, int code, bit inv, int j);
    int t, c;
    if (j < 0) return inv;
    t = (code == 7) ? j / 4096 : j;
    c = (p <= 1) ? 0 : t % p;
    return (c < d) ^ inv;
  endfunction

  task automatic wr(int ch, int r, logic [31:0] d);
    reg_addr = 6'((ch << 4) | (r << 2));
    reg_wdata = d;
    reg_we = 1'b1;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, int r, logic [31:0] exp, string tag);
    reg_addr = 6'((ch << 4) | (r << 2) | 1);
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic drain();
    while (q.size() != 0) begin @(posedge clk); #2; end
  endtask

  task automatic push(logic [3:0] v, string tag);
    item_t it;
    it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic setup(int ch, int duty, int tc, int ctl);
    wr(ch, 1, 32'(ctl));
    wr(ch, 2, 32'(duty));
    wr(ch, 3, 32'(tc));
  endtask

  task automatic run1(int ch, int duty, int tc, int code, bit inv, int n, string tag);
    int d, p;
    d = eff(duty, code); p = eff(tc, code);
    setup(ch, duty, tc, code | (inv ? 8 : 0));
    wr(ch, 0, 32'd1);
    for (int j = 0; j < n; j++) begin
      logic [3:0] v;
      v = bg;
      v[ch] = mdl(d, p, code, inv, j);
      push(v, tag);
    end
    drain();
  endtask

  task automatic stop(int ch, bit inv, string tag);
    wr(ch, 0, 32'd0);
    bg[ch] = inv;
    push(bg, tag);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R2: reset state
    chk(pwm_out === 4'b0, "R2 outputs after reset", 32'(pwm_out), 0);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) rd(c, r, 32'h0, "R2 register reset value");

    // R1: readback, masking of unused bits
    wr(3, 1, 32'hFFFF_FFFF); rd(3, 1, 32'hF, "R1 control readback");
    bg[3] = 1'b1;
    push(bg, "R6 inverted idle level"); drain();
    wr(3, 2, 32'hABCD_1234); rd(3, 2, 32'h1234, "R1 duty readback");
    wr(3, 3, 32'h5555_AAAA); rd(3, 3, 32'hAAAA, "R1 period readback");
    wr(3, 0, 32'hFFFF_FFFE); rd(3, 0, 32'h0, "R1 enable readback");
    rd(2, 2, 32'h0, "R1 other channel untouched");
    wr(3, 1, 32'h0); bg[3] = 1'b0;
    push(bg, "R6 normal idle level"); drain();

    // R4 basic waveform, R3 stop and restart from count 0
    run1(0, 3, 8, 0, 0, 24, "R4 duty 3 period 8");
    wr(0, 0, 32'd0);
    push(bg, "R3 output idle after disable"); drain();
    run1(0, 3, 8, 0, 0, 12, "R3 restart at count 0");
    stop(0, 0, "R3 disable");

    // R5 clamps
    run1(0, 0, 5, 0, 0, 10, "R5 zero duty");
    stop(0, 0, "R3 disable");
    run1(0, 9, 5, 0, 0, 10, "R5 duty above period");
    stop(0, 0, "R3 disable");
    run1(0, 5, 5, 0, 0, 10, "R5 duty equal period");
    stop(0, 0, "R3 disable");

    // R6 inversion
    run1(1, 2, 6, 0, 1, 12, "R6 inverted waveform");
    stop(1, 1, "R6 inverted idle after disable");
    wr(1, 1, 32'h0); bg[1] = 1'b0;

    // R7 shifted codes with truncation
    run1(0, 1, 16'h4003, 1, 0, 24, "R7 code 1 truncated period 12");
    stop(0, 0, "R3 disable");
    run1(0, 1, 16'h2002, 2, 0, 32, "R7 code 2 truncated period 16");
    stop(0, 0, "R3 disable");
    run1(0, 2, 16'h0401, 4, 0, 70, "R7 code 4 duty beyond truncated period");
    stop(0, 0, "R3 disable");

    // R8 divide by 4096
    run1(2, 1, 3, 7, 0, 3 * 4096 + 64, "R8 code 7 prescaled");
    stop(2, 0, "R3 disable");
    wr(2, 1, 32'h0);

    // R9 reload at boundary
    setup(0, 3, 10, 0);
    wr(0, 0, 32'd1);
    for (int j = 0; j < 22; j++) begin
      logic [3:0] v;
      v = bg;
      v[0] = (j < 10) ? mdl(3, 10, 0, 0, j) : mdl(2, 6, 0, 0, j - 10);
      push(v, "R9 new values at boundary");
    end
    repeat (3) begin @(posedge clk); #2; end
    wr(0, 2, 32'd2);
    wr(0, 3, 32'd6);
    drain();
    stop(0, 0, "R3 disable");

    // R10 independence
    setup(1, 1, 3, 0);
    setup(2, 2, 5, 0);
    wr(1, 0, 32'd1);
    wr(2, 0, 32'd1);
    for (int j = 0; j < 30; j++) begin
      logic [3:0] v;
      v = bg;
      v[1] = mdl(1, 3, 0, 0, j + 1);
      v[2] = mdl(2, 5, 0, 0, j);
      push(v, "R10 two channels staggered");
    end
    drain();
    wr(2, 0, 32'd0);
    for (int j = 0; j < 8; j++) begin
      logic [3:0] v;
      v = bg;
      v[1] = mdl(1, 3, 0, 0, j + 32);
      push(v, "R10 channel 1 unaffected by channel 2 stop");
    end
    drain();
    stop(1, 0, "R3 disable");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule